// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home-node end of a directory coherence scheme for a small distributed shared-memory machine. For each memory block it keeps a directory entry and a data word in internal storage. The entry holds one of three coherence states and a vector with one presence bit per processor. Caches send it read misses, write misses and write-backs. Point-to-point messages take the place of a snooped bus. The controller answers each miss with a data reply. When other caches must give up or return a copy, it sends them invalidate, fetch or fetch-and-invalidate commands.

Requests are handled one at a time and in arrival order. If a block is held exclusively by another cache, the controller sends a command to the owner and then waits for that owner's write-back. While it waits, `busy` is high and every other request is dropped, so a requester has to resend it later. A combinational lookup port shows the entry of any block, which lets scripted sequences check the directory's final contents.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is Uncached (state code 0) with an empty sharer vector, every data word is zero, and `busy`, `rep_valid` and `cmd_valid` are low.
- R2: A read miss (`req_kind` 0) to an Uncached or Shared block pulses `rep_valid` for one cycle, starting the cycle after acceptance. The pulse carries the stored word, the requester as `rep_dest` and the block address. The entry becomes Shared (code 1) and the requester's bit is added.
- R3: A read miss to an Exclusive block (code 2) sends command 1 (fetch) to the owner the cycle after acceptance, with only the owner's bit set in `cmd_mask`, and raises `busy`. The owner's write-back then stores its data and replies with that data to the reader. The entry becomes Shared with the owner's and the reader's bits set.
- R4: A write miss (`req_kind` 1) to an Uncached block replies with the stored word and sends no command. The entry becomes Exclusive with only the requester's bit set.
- R5: A write miss to a Shared block sends command 0 (invalidate) to every sharer except the requester, in the same cycle as the data reply. No command goes out when the requester is the only sharer. The entry becomes Exclusive with only the requester's bit set.
- R6: A write miss to a block held Exclusive by another processor sends command 2 (fetch-and-invalidate) to the owner and raises `busy`. The owner's write-back stores its data and replies with it to the writer. The entry becomes Exclusive owned by the writer.
- R7: A write-back (`req_kind` 2) from the owner of an Exclusive block stores its data, produces no reply and leaves the entry Uncached and empty. A write-back from any processor that is not the exclusive owner has no effect on data or directory.
- R8: While `busy` is high, every request other than the awaited owner's write-back to the pending block is ignored: no reply, no command, no directory change.
- R9: A write miss from the processor that already owns the block exclusively replies with the stored word, sends no command and leaves the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request message present this cycle |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | $clog2(N_PROC) | Sending processor |
| req_addr | input | $clog2(N_BLOCKS) | Block address |
| req_data | input | DATA_W | Write-back data |
| busy | output | 1 | Waiting for an owner's write-back; other requests are dropped |
| cmd_valid | output | 1 | Command to remote caches this cycle |
| cmd_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate |
| cmd_mask | output | N_PROC | Target processors, one bit each |
| cmd_addr | output | $clog2(N_BLOCKS) | Block the command refers to |
| rep_valid | output | 1 | Data reply this cycle |
| rep_dest | output | $clog2(N_PROC) | Processor receiving the reply |
| rep_addr | output | $clog2(N_BLOCKS) | Block of the reply |
| rep_data | output | DATA_W | Reply data word |
| look_addr | input | $clog2(N_BLOCKS) | Block to inspect |
| look_state | output | 2 | State of the inspected entry |
| look_sharers | output | N_PROC | Sharer vector of the inspected entry |

## Verification
A corrupted sharer vector shows up at the ports within one cycle of the next miss to that block. An invalidate mask would name the wrong caches, or a fetch would go to the wrong owner. A wrong state code shows up as the wrong kind of response: a reply where a fetch was due, or a stall where a reply was due. A wrong memory word only appears when the block is next read, so scripted sequences read blocks back after write-backs and after ignored write-backs. Each step also compares the lookup port against the expected entry.

// File: rtl/dir_pkg.sv
// Shared encodings for the home-node directory controller.
// Assumes every block is in exactly one of three coherence states.
package dir_pkg;
    typedef enum logic [1:0] {
        ST_UNC = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        MSG_RD = 2'd0,
        MSG_WR = 2'd1,
        MSG_WB = 2'd2
    } msg_kind_e;

    typedef enum logic [1:0] {
        CMD_INV       = 2'd0,
        CMD_FETCH     = 2'd1,
        CMD_FETCH_INV = 2'd2
    } cmd_kind_e;
endpackage

// File: rtl/dir_entry_table.sv
// Directory entries: one coherence state and one sharer vector per block.
// One combinational read port for the controller, one for lookup, one write port.
// Assumes the controller writes a consistent state/sharer pair.
module dir_entry_table
    import dir_pkg::*;
#(
    parameter int N_PROC   = 4,
    parameter int N_BLOCKS = 16,
    localparam int AW      = $clog2(N_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr,
    output dir_state_e        rd_state,
    output logic [N_PROC-1:0] rd_sharers,
    input  logic [AW-1:0]     lk_addr,
    output dir_state_e        lk_state,
    output logic [N_PROC-1:0] lk_sharers,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  dir_state_e        wr_state,
    input  logic [N_PROC-1:0] wr_sharers
);
    dir_state_e        state_q   [N_BLOCKS];
    logic [N_PROC-1:0] sharers_q [N_BLOCKS];

    // Clear all entries on reset, otherwise apply the controller's update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BLOCKS; i++) begin
                state_q[i]   <= ST_UNC;
                sharers_q[i] <= '0;
            end
        end else if (wr_en) begin
            state_q[wr_addr]   <= wr_state;
            sharers_q[wr_addr] <= wr_sharers;
        end
    end

    // Read ports are plain array lookups.
    always_comb begin
        rd_state   = state_q[rd_addr];
        rd_sharers = sharers_q[rd_addr];
        lk_state   = state_q[lk_addr];
        lk_sharers = sharers_q[lk_addr];
    end

    // R4 R6 R9
    excl_one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_state == ST_EXC |-> $countones(wr_sharers) == 1);
    // R7
    unc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_state == ST_UNC |-> wr_sharers == '0);
    // R2 R3
    shr_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_state == ST_SHR |-> wr_sharers != '0);
endmodule

// File: rtl/dir_data_mem.sv
// Home memory: one data word per block, zeroed by reset.
// Combinational read, single synchronous write.
module dir_data_mem #(
    parameter int N_BLOCKS = 16,
    parameter int DATA_W   = 16,
    localparam int AW      = $clog2(N_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] word_q [N_BLOCKS];

    // Zero memory on reset, otherwise store write-back data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BLOCKS; i++) word_q[i] <= '0;
        end else if (wr_en) begin
            word_q[wr_addr] <= wr_data;
        end
    end

    // Combinational read of the addressed word.
    always_comb rd_data = word_q[rd_addr];
endmodule

// File: rtl/dir_owner_enc.sv
// Turns a sharer vector into a processor index.
// Assumes the vector is one-hot (Exclusive entries); other inputs OR the indices together.
module dir_owner_enc #(
    parameter int N_PROC = 4,
    localparam int IDW   = $clog2(N_PROC)
) (
    input  logic [N_PROC-1:0] vec,
    output logic [IDW-1:0]    idx
);
    logic [IDW-1:0] part [N_PROC+1];

    assign part[0] = '0;
    for (genvar g = 0; g < N_PROC; g++) begin : g_enc
        assign part[g+1] = part[g] | (vec[g] ? IDW'(g) : '0);
    end
    assign idx = part[N_PROC];
endmodule

// File: rtl/dir_home_ctrl.sv
// Home-node directory controller. It accepts one request per cycle when idle,
// updates the entry and the memory, and issues registered replies and commands one
// cycle after acceptance. After a fetch it waits for the owner's write-back and drops
// every other request. Assumes in-order delivery and senders that resend dropped requests.
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int N_PROC   = 4,
    parameter int N_BLOCKS = 16,
    parameter int DATA_W   = 16,
    localparam int IDW     = $clog2(N_PROC),
    localparam int AW      = $clog2(N_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [IDW-1:0]    req_src,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [N_PROC-1:0] cmd_mask,
    output logic [AW-1:0]     cmd_addr,
    output logic              rep_valid,
    output logic [IDW-1:0]    rep_dest,
    output logic [AW-1:0]     rep_addr,
    output logic [DATA_W-1:0] rep_data,
    input  logic [AW-1:0]     look_addr,
    output logic [1:0]        look_state,
    output logic [N_PROC-1:0] look_sharers
);
    logic              wait_q, pend_wr_q;
    logic [IDW-1:0]    pend_src_q;
    logic [AW-1:0]     pend_addr_q;

    logic [AW-1:0]     sel_addr;
    dir_state_e        cur_state, lk_state, tbl_state;
    logic [N_PROC-1:0] cur_sh, tbl_sh, req_bit, pend_bit;
    logic [IDW-1:0]    owner;
    logic [DATA_W-1:0] mem_rd, mem_wd;
    logic              tbl_we, mem_we, start_wait, end_wait;
    logic              n_rep, n_cmd;
    cmd_kind_e         n_cmd_kind;
    logic [N_PROC-1:0] n_cmd_mask;
    logic [DATA_W-1:0] n_rep_data;
    msg_kind_e         kind;

    assign sel_addr = wait_q ? pend_addr_q : req_addr;
    assign kind     = msg_kind_e'(req_kind);

    dir_entry_table #(.N_PROC(N_PROC), .N_BLOCKS(N_BLOCKS)) i_table (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(sel_addr), .rd_state(cur_state), .rd_sharers(cur_sh),
        .lk_addr(look_addr), .lk_state(lk_state), .lk_sharers(look_sharers),
        .wr_en(tbl_we), .wr_addr(sel_addr), .wr_state(tbl_state), .wr_sharers(tbl_sh)
    );

    dir_data_mem #(.N_BLOCKS(N_BLOCKS), .DATA_W(DATA_W)) i_mem (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(sel_addr), .rd_data(mem_rd),
        .wr_en(mem_we), .wr_addr(sel_addr), .wr_data(mem_wd)
    );

    dir_owner_enc #(.N_PROC(N_PROC)) i_owner (.vec(cur_sh), .idx(owner));

    assign look_state = lk_state;

    // One-hot masks of the requester and of the pending requester.
    always_comb begin
        req_bit  = '0;
        req_bit[req_src] = 1'b1;
        pend_bit = '0;
        pend_bit[pend_src_q] = 1'b1;
    end

    // Decide the entry update, memory write and outgoing messages for this cycle.
    always_comb begin
        tbl_we = 1'b0; tbl_state = cur_state; tbl_sh = cur_sh;
        mem_we = 1'b0; mem_wd = req_data;
        n_rep = 1'b0; n_rep_data = mem_rd;
        n_cmd = 1'b0; n_cmd_kind = CMD_INV; n_cmd_mask = '0;
        start_wait = 1'b0; end_wait = 1'b0;
        if (wait_q) begin
            if (req_valid && kind == MSG_WB && req_addr == pend_addr_q && req_bit == cur_sh) begin
                end_wait   = 1'b1;
                mem_we     = 1'b1;
                n_rep      = 1'b1;
                n_rep_data = req_data;
                tbl_we     = 1'b1;
                tbl_state  = pend_wr_q ? ST_EXC : ST_SHR;
                tbl_sh     = pend_wr_q ? pend_bit : (cur_sh | pend_bit);
            end
        end else if (req_valid) begin
            unique case (kind)
                MSG_RD: begin
                    if (cur_state == ST_EXC) begin
                        n_cmd = 1'b1; n_cmd_kind = CMD_FETCH; n_cmd_mask = cur_sh;
                        start_wait = 1'b1;
                    end else begin
                        n_rep = 1'b1;
                        tbl_we = 1'b1; tbl_state = ST_SHR; tbl_sh = cur_sh | req_bit;
                    end
                end
                MSG_WR: begin
                    if (cur_state == ST_EXC && cur_sh != req_bit) begin
                        n_cmd = 1'b1; n_cmd_kind = CMD_FETCH_INV; n_cmd_mask = cur_sh;
                        start_wait = 1'b1;
                    end else begin
                        n_rep = 1'b1;
                        n_cmd_mask = cur_sh & ~req_bit;
                        n_cmd = (cur_state == ST_SHR) && (n_cmd_mask != '0);
                        tbl_we = 1'b1; tbl_state = ST_EXC; tbl_sh = req_bit;
                    end
                end
                MSG_WB: begin
                    if (cur_state == ST_EXC && cur_sh == req_bit) begin
                        mem_we = 1'b1;
                        tbl_we = 1'b1; tbl_state = ST_UNC; tbl_sh = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Register the outgoing messages and the pending-request context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= 1'b0; pend_wr_q <= 1'b0; pend_src_q <= '0; pend_addr_q <= '0;
            rep_valid <= 1'b0; rep_dest <= '0; rep_addr <= '0; rep_data <= '0;
            cmd_valid <= 1'b0; cmd_kind <= '0; cmd_mask <= '0; cmd_addr <= '0;
        end else begin
            rep_valid <= n_rep;
            rep_data  <= n_rep_data;
            rep_dest  <= wait_q ? pend_src_q : req_src;
            rep_addr  <= sel_addr;
            cmd_valid <= n_cmd;
            cmd_kind  <= n_cmd_kind;
            cmd_mask  <= n_cmd_mask;
            cmd_addr  <= sel_addr;
            if (start_wait) begin
                wait_q      <= 1'b1;
                pend_wr_q   <= (kind == MSG_WR);
                pend_src_q  <= req_src;
                pend_addr_q <= req_addr;
            end else if (end_wait) begin
                wait_q <= 1'b0;
            end
        end
    end

    assign busy = wait_q;

    // Owner is only meaningful while a single bit is set; keep it observable for checks.
    // R3 R6
    fetch_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cmd_valid && cmd_kind != CMD_INV && $countones(cmd_mask) == 1);
    // R5
    inv_spares_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == CMD_INV |-> rep_valid && !cmd_mask[rep_dest]);
    // R8
    stall_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> !rep_valid && !cmd_valid);
    // R3 R6
    fetch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_wait |-> cur_sh[owner]);
endmodule

// File: tb/test_dir_home_ctrl.sv
// Scoreboard bench: the driver pushes expected replies and commands into queues,
// and a monitor pops and compares them whenever the design emits a message.
module test_dir_home_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4, NB = 16, DW = 16;
    localparam int IDW = $clog2(NP), AW = $clog2(NB);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic [IDW-1:0] req_src = '0;
    logic [AW-1:0] req_addr = '0, look_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic busy, cmd_valid, rep_valid;
    logic [1:0] cmd_kind, look_state;
    logic [NP-1:0] cmd_mask, look_sharers;
    logic [AW-1:0] cmd_addr, rep_addr;
    logic [IDW-1:0] rep_dest;
    logic [DW-1:0] rep_data;

    int n_cmp = 0, n_bad = 0;

    typedef logic [IDW+AW+DW-1:0] rep_t;
    typedef logic [2+NP+AW-1:0]   cmd_t;
    rep_t  rep_q[$];  string rep_tag[$];
    cmd_t  cmd_q[$];  string cmd_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dir_home_ctrl #(.N_PROC(NP), .N_BLOCKS(NB), .DATA_W(DW)) i_dir_home_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_src(req_src), .req_addr(req_addr), .req_data(req_data), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_mask(cmd_mask), .cmd_addr(cmd_addr),
        .rep_valid(rep_valid), .rep_dest(rep_dest), .rep_addr(rep_addr), .rep_data(rep_data),
        .look_addr(look_addr), .look_state(look_state), .look_sharers(look_sharers));

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare every emitted reply and command.
    always @(negedge clk) begin
        if (rst_n && rep_valid) begin
            if (rep_q.size() == 0) cmp("R8 unexpected reply", {rep_dest, rep_addr, rep_data}, '1);
            else cmp(rep_tag.pop_front(), {rep_dest, rep_addr, rep_data}, rep_q.pop_front());
        end
        if (rst_n && cmd_valid) begin
            if (cmd_q.size() == 0) cmp("R8 unexpected command", {cmd_kind, cmd_mask, cmd_addr}, '1);
            else cmp(cmd_tag.pop_front(), {cmd_kind, cmd_mask, cmd_addr}, cmd_q.pop_front());
        end
    end

    task automatic exp_rep(input string tag, input int dst, input int a, input int d);
        rep_q.push_back({IDW'(dst), AW'(a), DW'(d)}); rep_tag.push_back(tag);
    endtask
    task automatic exp_cmd(input string tag, input int k, input int m, input int a);
        cmd_q.push_back({2'(k), NP'(m), AW'(a)}); cmd_tag.push_back(tag);
    endtask

    // Driver: present one request for one clock, then return at the next falling edge.
    task automatic send(input int k, input int s, input int a, input int d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(k); req_src = IDW'(s); req_addr = AW'(a); req_data = DW'(d);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    task automatic check_dir(input string tag, input int a, input int st, input int sh);
        look_addr = AW'(a);
        #1;
        cmp(tag, {look_state, look_sharers}, {2'(st), NP'(sh)});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        cmp("R1 busy", busy, 0);
        cmp("R1 outputs", {rep_valid, cmd_valid}, 0);
        check_dir("R1 entry 0", 0, 0, 0);
        check_dir("R1 entry 5", 5, 0, 0);

        // R7 write-back to an uncached block is ignored; R1 memory zero
        send(2, 1, 3, 16'h7777);
        check_dir("R7 ignored wb state", 3, 0, 0);
        exp_rep("R2 R1 read zero", 0, 3, 0);
        send(0, 0, 3, 0);
        check_dir("R2 shared p0", 3, 1, 4'b0001);
        exp_rep("R2 second reader", 2, 3, 0);
        send(0, 2, 3, 0);
        check_dir("R2 shared p0 p2", 3, 1, 4'b0101);

        // R5 write miss in Shared invalidates others
        exp_cmd("R5 invalidate p0", 0, 4'b0001, 3);
        exp_rep("R5 reply writer", 2, 3, 0);
        send(1, 2, 3, 0);
        check_dir("R5 exclusive p2", 3, 2, 4'b0100);

        // R3 read miss in Exclusive fetches from owner; R8 stall drops others
        exp_cmd("R3 fetch owner", 1, 4'b0100, 3);
        send(0, 1, 3, 0);
        cmp("R3 busy", busy, 1);
        send(1, 3, 7, 0);
        cmp("R8 still busy", busy, 1);
        check_dir("R8 entry 7 untouched", 7, 0, 0);
        check_dir("R8 entry 3 untouched", 3, 2, 4'b0100);
        exp_rep("R3 forwarded data", 1, 3, 16'hBEEF);
        send(2, 2, 3, 16'hBEEF);
        cmp("R3 busy cleared", busy, 0);
        check_dir("R3 shared owner+reader", 3, 1, 4'b0110);

        // R5 two sharers invalidated
        exp_cmd("R5 invalidate p1 p2", 0, 4'b0110, 3);
        exp_rep("R5 reply p3", 3, 3, 16'hBEEF);
        send(1, 3, 3, 0);
        check_dir("R5 exclusive p3", 3, 2, 4'b1000);

        // R6 write miss in Exclusive held by another
        exp_cmd("R6 fetch-inv owner", 2, 4'b1000, 3);
        send(1, 0, 3, 0);
        cmp("R6 busy", busy, 1);
        exp_rep("R6 reply writer", 0, 3, 16'h1234);
        send(2, 3, 3, 16'h1234);
        check_dir("R6 exclusive p0", 3, 2, 4'b0001);

        // R9 write miss by the current owner
        exp_rep("R9 owner rewrite", 0, 3, 16'h1234);
        send(1, 0, 3, 0);
        check_dir("R9 unchanged", 3, 2, 4'b0001);

        // R7 non-owner write-back ignored, owner write-back uncaches
        send(2, 1, 3, 16'hDEAD);
        check_dir("R7 non-owner ignored", 3, 2, 4'b0001);
        send(2, 0, 3, 16'h5555);
        check_dir("R7 uncached", 3, 0, 0);
        exp_rep("R7 R2 memory updated", 1, 3, 16'h5555);
        send(0, 1, 3, 0);
        check_dir("R2 shared p1", 3, 1, 4'b0010);

        // R4 write miss in Uncached
        exp_rep("R4 reply", 2, 9, 0);
        send(1, 2, 9, 0);
        check_dir("R4 exclusive p2", 9, 2, 4'b0100);

        // R5 sole sharer upgrades with no command
        exp_rep("R5 sole sharer reply", 1, 3, 16'h5555);
        send(1, 1, 3, 0);
        check_dir("R5 exclusive p1", 3, 2, 4'b0010);

        repeat (3) @(negedge clk);
        cmp("R8 no pending replies", rep_q.size(), 0);
        cmp("R8 no pending commands", cmd_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule